// File: doc/BRIEF.md
# Fractional-Rate Serial Transmitter

This block turns a stream of bytes into an asynchronous serial line. The bit rate comes from a phase accumulator instead of an integer divider. Every clock, a 16-bit increment is added into a 20-bit accumulator, and each carry out of the top bit marks the end of one bit time. This gives a bit rate of increment × f_clk / 2^20 with fine resolution, even when the clock is not a multiple of the wanted baud rate.

Bytes come from an upstream FIFO through a valid/ready handshake. A byte is taken only on a bit tick, and only while the transmit enable is set. The byte is then framed as a low start bit, eight data bits sent least significant first, an optional parity bit, and a high stop bit. A 32-bit control word drives the block. Its upper half is the increment, bit 0 is the transmit enable, bit 6 enables parity and bit 7 selects odd parity.

Top module: `uart_nco_tx`

## Requirements
- R1: After reset, tx_o is high (idle) and byte_ready_o is low.
- R2: The accumulator is 20 bits wide, and ctrl_i[31:16] is added to it every clock. A bit tick occurs in each cycle whose addition carries out of bit 19, so one bit time spans the cycles between ticks. With an increment of 0x8000 this is exactly 32 cycles.
- R3: With parity off (ctrl_i[6]=0), a character occupies 10 bit times: one low start bit, data bits 0 to 7 in that order, and one high stop bit.
- R4: With ctrl_i[6]=1, one parity bit follows data bit 7, giving 11 bit times. If ctrl_i[7]=0 the parity bit is the XOR of the data (even parity). If ctrl_i[7]=1 it is its complement (odd parity).
- R5: byte_ready_o is high only in a tick cycle with ctrl_i[0]=1 while no character is in flight or its stop bit is completing. The byte is taken when byte_valid_i is also high, and tx_o goes low in the next cycle.
- R6: When a byte is waiting, it is taken on the tick that ends the previous stop bit. Back-to-back characters therefore leave no idle gap (10 bit times apart without parity).
- R7: Clearing ctrl_i[0] in the middle of a character lets that character finish. No further byte is taken, and tx_o stays high afterwards.
- R8: An increment of zero produces no ticks. byte_ready_o stays low and an idle line stays high.
- R9: tx_o changes only in the cycle that follows a tick.
- R10: The data and the parity settings are captured when the byte is taken. Changing ctrl_i[7:6] during a character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: [31:16] increment, [7] odd parity, [6] parity enable, [0] transmit enable |
| byte_i | input | 8 | Byte offered by the FIFO |
| byte_valid_i | input | 1 | byte_i holds a byte |
| byte_ready_o | output | 1 | Byte is taken this cycle when valid |
| tx_o | output | 1 | Serial line, idles high |

## Verification
byte_ready_o is combinational. It is due in the same cycle as the tick, so the bench compares it against the model after that cycle's falling edge, once the inputs have settled. tx_o is a register that moves one cycle after a tick. The bench's reference model updates its line value at the same rising edge and compares it 2 ns after the next falling edge, so no sample lands on the edge itself. Accept instants are logged by cycle number, so the bit time (32 cycles at 0x8000) and the back-to-back spacing (320 cycles) are checked as exact differences.

// File: rtl/uart_nco_pkg.sv
package uart_nco_pkg;
  localparam int CTRL_TX_EN    = 0;
  localparam int CTRL_PAR_EN   = 6;
  localparam int CTRL_PAR_ODD  = 7;
  localparam int CTRL_INC_LSB  = 16;

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/uart_nco_tick.sv
module uart_nco_tick #(
  parameter int INC_W = 16,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + (ACC_W+1)'(inc_i);
  assign tick_o = sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int SH_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] left_q;
  logic             busy_q, tx_q, accept, par;

  // take a byte on a tick when idle or when the stop bit is ending
  assign ready_o = tick_i & en_i & (~busy_q | (left_q == '0));
  assign accept  = ready_o & valid_i;
  assign par     = (^data_i) ^ par_odd_i;
  assign busy_o  = busy_q;
  assign tx_o    = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
      sh_q   <= '1;
      left_q <= '0;
    end else if (tick_i) begin
      if (accept) begin
        busy_q <= 1'b1;
        tx_q   <= 1'b0;
        sh_q   <= par_en_i ? {1'b1, par, data_i} : {2'b11, data_i};
        left_q <= par_en_i ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
      end else if (busy_q && left_q != '0) begin
        tx_q   <= sh_q[0];
        sh_q   <= {1'b1, sh_q[SH_W-1:1]};
        left_q <= left_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_nco_tx.sv
module uart_nco_tx
  import uart_nco_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int INC_W  = 16,
  parameter int ACC_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ctrl_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              tx_o
);
  logic nco_tick, frm_busy;
  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i[15:8], ctrl_i[5:1]};

  uart_nco_tick #(.INC_W(INC_W), .ACC_W(ACC_W)) u_nco (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ctrl_i[CTRL_INC_LSB +: INC_W]),
    .tick_o (nco_tick)
  );

  uart_tx_frame #(.DATA_W(DATA_W)) u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (nco_tick),
    .en_i      (ctrl_i[CTRL_TX_EN]),
    .par_en_i  (ctrl_i[CTRL_PAR_EN]),
    .par_odd_i (ctrl_i[CTRL_PAR_ODD]),
    .data_i    (byte_i),
    .valid_i   (byte_valid_i),
    .ready_o   (byte_ready_o),
    .busy_o    (frm_busy),
    .tx_o      (tx_o)
  );
endmodule

// File: rtl/uart_nco_tx_chk.sv
module uart_nco_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic [15:0] inc_i,
  input logic        byte_valid_i,
  input logic        byte_ready_o,
  input logic        tx_o,
  input logic        tick,
  input logic        busy
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o);
  assert_ready_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (en_i && tick));
  assert_start_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_ready_o) |=> !tx_o);
  assert_b2b_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && byte_ready_o) |-> tx_o);
  assert_zero_inc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == 16'h0) |-> (!tick && !byte_ready_o));
  assert_tx_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(tx_o));
endmodule

bind uart_nco_tx uart_nco_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (ctrl_i[0]),
  .inc_i        (ctrl_i[31:16]),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .tx_o         (tx_o),
  .tick         (nco_tick),
  .busy         (frm_busy)
);

// File: tb/uart_nco_tx_test.sv
module uart_nco_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic [7:0]  bdata = '0;
  logic        bvalid = 1'b0;
  logic        rdy, tx;

  always #5 clk = ~clk;

  uart_nco_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .byte_i(bdata),
    .byte_valid_i(bvalid), .byte_ready_o(rdy), .tx_o(tx)
  );

  int    checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  logic [7:0] stim_q[$];
  int    acc_cyc[$];
  int    m_acc = 0;
  bit    m_busy = 0, m_tx = 1, m_t, m_r;
  bit    m_bits[$];

  function automatic bit m_tick();
    return (m_acc + int'(ctrl[31:16])) >= (1 << 20);
  endfunction
  function automatic bit m_ready();
    return m_tick() && ctrl[0] && (!m_busy || m_bits.size() == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // stimulus: offer the head of the queue, refreshed after each edge
  always @(posedge clk) begin
    #1;
    bvalid = stim_q.size() != 0;
    bdata  = (stim_q.size() != 0) ? stim_q[0] : 8'h00;
  end

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_busy = 0; m_tx = 1; m_bits.delete();
    end else begin
      cyc++;
      m_t = m_tick();
      m_r = m_ready();
      if (m_t) begin
        if (m_busy && m_bits.size() > 0) m_tx = m_bits.pop_front();
        else if (m_r && bvalid) begin
          m_tx = 0; m_busy = 1;
          for (int i = 0; i < 8; i++) m_bits.push_back(bdata[i]);
          if (ctrl[6]) m_bits.push_back((^bdata) ^ ctrl[7]);
          m_bits.push_back(1'b1);
          void'(stim_q.pop_front());
        end else m_busy = 0;
      end
      m_acc = (m_acc + int'(ctrl[31:16])) % (1 << 20);
    end
  end

  // per-cycle comparison away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(tx === m_tx, tag, "tx_o", int'(tx), int'(m_tx));
      chk(rdy === m_ready(), tag, "byte_ready_o", int'(rdy), int'(m_ready()));
      if (rdy && bvalid) acc_cyc.push_back(cyc);
    end
  end

  task automatic wait_idle();
    int n = 0;
    while ((m_busy || stim_q.size() != 0) && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(tx === 1'b1, "R1", "reset tx_o", int'(tx), 1);
    chk(rdy === 1'b0, "R1", "reset byte_ready_o", int'(rdy), 0);

    // R8: zero increment never ticks
    tag = "R8"; ctrl = 32'h0000_0001; stim_q.push_back(8'h55);
    repeat (300) @(negedge clk); #3;
    chk(acc_cyc.size() == 0, "R8", "accepts with zero increment", acc_cyc.size(), 0);
    chk(tx === 1'b1, "R8", "idle line", int'(tx), 1);
    stim_q.delete();
    repeat (3) @(negedge clk);

    // R3 / R6 / R2: no parity, back-to-back, exact spacing
    tag = "R3"; acc_cyc.delete(); ctrl = {16'h8000, 16'h0001};
    stim_q.push_back(8'hA5); stim_q.push_back(8'h3C);
    wait_idle();
    chk(acc_cyc.size() == 2, "R6", "bytes taken", acc_cyc.size(), 2);
    if (acc_cyc.size() == 2)
      chk(acc_cyc[1] - acc_cyc[0] == 320, "R2", "cycles between accepts (R6 no gap)", acc_cyc[1] - acc_cyc[0], 320);

    // R4: even then odd parity, fractional rate
    tag = "R4"; ctrl = {16'h3000, 16'h0041};
    stim_q.push_back(8'h01); stim_q.push_back(8'hFF);
    wait_idle();
    ctrl = {16'h3000, 16'h00C1};
    stim_q.push_back(8'h00); stim_q.push_back(8'h7E);
    wait_idle();

    // R10: parity settings change mid-character
    tag = "R10"; ctrl = {16'h8000, 16'h0041}; stim_q.push_back(8'h96);
    repeat (100) @(negedge clk);
    ctrl = {16'h8000, 16'h00C1};
    repeat (100) @(negedge clk);
    ctrl = {16'h8000, 16'h0001};
    wait_idle();

    // R5: no byte taken while enable is clear
    tag = "R5"; acc_cyc.delete(); ctrl = {16'h8000, 16'h0000}; stim_q.push_back(8'h5A);
    repeat (200) @(negedge clk); #3;
    chk(acc_cyc.size() == 0, "R5", "accepts while disabled", acc_cyc.size(), 0);
    ctrl = {16'h8000, 16'h0001};
    wait_idle();
    chk(acc_cyc.size() == 1, "R5", "accepts after enable", acc_cyc.size(), 1);

    // R7: disable mid-character finishes it and stops
    tag = "R7"; acc_cyc.delete(); ctrl = {16'h8000, 16'h0001};
    stim_q.push_back(8'h11); stim_q.push_back(8'h22); stim_q.push_back(8'h33);
    repeat (100) @(negedge clk);
    ctrl = {16'h8000, 16'h0000};
    repeat (700) @(negedge clk); #3;
    chk(acc_cyc.size() == 1, "R7", "bytes taken after disable", acc_cyc.size(), 1);
    chk(tx === 1'b1, "R7", "line after finish", int'(tx), 1);
    chk(stim_q.size() == 2, "R7", "bytes left waiting", stim_q.size(), 2);
    stim_q.delete();
    repeat (3) @(negedge clk);

    // R9: odd increment, line moves only after ticks
    tag = "R9"; ctrl = {16'h1234, 16'h0041};
    stim_q.push_back(8'hC3); stim_q.push_back(8'h0F);
    wait_idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule